// File: doc/BRIEF.md
# Low-Power Mode and Peripheral Clock Gating Controller

This block decides when the processor, the peripherals and the main oscillator receive clocks. Software writes a mode word to request one of two sleep depths. In the shallow depth only the processor clock stops, and any pending interrupt restarts it. In the deep depth the oscillator is switched off, so every clock stops. Only a wake line that can be detected without a clock, or a reset, ends the deep depth. All register and memory state is kept through both depths, because the clocks are gated and not reset.

When the block leaves the deep depth, it enables the oscillator first. It keeps the processor and peripheral clocks off for a programmable start-up count so that the oscillator can settle. A separate per-peripheral mask switches off any peripheral that is not needed. A cleared mask bit holds that peripheral's clock enable low in every mode. The clock enables are level signals meant for glitch-free gating cells placed outside this block. The wake lines are asynchronous and pass through a synchronizer before they are used.

Top module: `lowpwr_ctrl`

## Requirements
- R1: After a synchronous reset, `cpu_clk_en` and `osc_en` are 1 and every bit of `periph_clk_en` is 1. The peripheral mask resets to all ones and the start-up count resets to `STARTUP_RST`.
- R2: A write to address 0 with data bit 0 set and bit 1 clear enters idle on that clock edge. In idle, `cpu_clk_en` is 0, `osc_en` stays 1 and `periph_clk_en` equals the mask.
- R3: Idle ends at the first edge where any `irq_pending` bit is 1, or where a wake line has reached the end of its 2-flop synchronizer. `cpu_clk_en` is 1 after that edge.
- R4: A mode write with data bit 1 set enters power-down on that edge, whatever the value of bit 0. In power-down, `osc_en`, `cpu_clk_en` and all of `periph_clk_en` are 0.
- R5: `irq_pending` has no effect in power-down.
- R6: A synchronized wake line ends power-down. `osc_en` rises after that edge. `cpu_clk_en` and `periph_clk_en` then stay 0 for exactly N+1 cycles, where N is the start-up count. After that, both return to their run values.
- R7: A write to address 2 loads the start-up count from `reg_wdata[CNT_W-1:0]`. The value 0 gives a one-cycle wait.
- R8: A write to address 1 loads the mask from `reg_wdata[NPER-1:0]`. A mask bit of 0 forces that `periph_clk_en` bit to 0 in every mode.
- R9: The sleep request clears itself on wake. After a wake the block stays in run until a new mode write arrives.
- R10: Mode writes are ignored while the block is not in run. A write to address 3 changes nothing.
- R11: A reset applied in any state, power-down included, restores the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock for this block |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 mask, 2 start-up count, 3 unused |
| reg_wdata | input | WDATA_W | Write data |
| irq_pending | input | NIRQ | Pending, enabled interrupt vector |
| wake_async | input | NWAKE | Asynchronous wake lines that work without a clock |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | NPER | Per-peripheral clock enables |
| osc_en | output | 1 | Oscillator enable |

## Verification
The embedded properties check these rules on every cycle:
- Power-down holds until a synchronized wake arrives.
- Idle always ends on the edge after an interrupt or wake.
- The start-up counter decrements by exactly one each cycle.
- Run is kept without a new mode write.
- A stopped oscillator always comes with all clock enables low.

Only the scenarios can show the following:
- The exact start-up length for different programmed counts.
- That a pulse on `irq_pending` is ignored in power-down.
- That writes to unused addresses and mode writes made during sleep are ignored.
- That reset clears the mask from the deep depth.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_IDLE    = 2'd1,
        PM_PDOWN   = 2'd2,
        PM_OSCWAIT = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        PM_ADDR_MODE  = 2'd0,
        PM_ADDR_MASK  = 2'd1,
        PM_ADDR_START = 2'd2,
        PM_ADDR_NONE  = 2'd3
    } pm_addr_e;

    typedef struct packed {
        logic pdown;
        logic idle;
    } pm_req_t;

    typedef struct packed {
        logic cpu;
        logic osc;
        logic periph;
    } pm_gate_t;

    function automatic int pm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // power-down wins over idle when both request bits are set
    function automatic pm_state_e pm_target(input pm_req_t req);
        if (req.pdown)
            return PM_PDOWN;
        else if (req.idle)
            return PM_IDLE;
        else
            return PM_RUN;
    endfunction

    function automatic pm_gate_t pm_gates(input pm_state_e st);
        pm_gate_t g;
        g.cpu    = (st == PM_RUN);
        g.osc    = (st != PM_PDOWN);
        g.periph = (st == PM_RUN) || (st == PM_IDLE);
        return g;
    endfunction

endpackage

// File: rtl/pm_wake_sync.sv
module pm_wake_sync #(
    parameter int NWAKE  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NWAKE-1:0] wake_async,
    output logic [NWAKE-1:0] wake_sync,
    output logic             wake_any
);

    genvar gi;
    generate
        for (gi = 0; gi < NWAKE; gi++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst)
                    chain <= '0;
                else
                    chain <= {chain[STAGES-2:0], wake_async[gi]};
            end
            assign wake_sync[gi] = chain[STAGES-1];
        end
    endgenerate

    assign wake_any = |wake_sync;

endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_pkg::*;
#(
    parameter int NPER        = 8,
    parameter int CNT_W       = 8,
    parameter int WDATA_W     = 8,
    parameter int STARTUP_RST = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  pm_addr_e           reg_addr,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [NPER-1:0]    per_mask,
    output logic [CNT_W-1:0]   startup_cnt
);

    localparam logic [CNT_W-1:0] START_INIT = CNT_W'(STARTUP_RST);

    logic wr_mask;
    logic wr_start;

    assign wr_mask  = reg_wr && (reg_addr == PM_ADDR_MASK);
    assign wr_start = reg_wr && (reg_addr == PM_ADDR_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_mask    <= '1;
            startup_cnt <= START_INIT;
        end else begin
            if (wr_mask)
                per_mask <= reg_wdata[NPER-1:0];
            if (wr_start)
                startup_cnt <= reg_wdata[CNT_W-1:0];
        end
    end

    // R1
    mask_after_reset_chk: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (per_mask == '1));

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr,
    input  pm_req_t          mode_req,
    input  logic             irq_any,
    input  logic             wake_any,
    input  logic [CNT_W-1:0] startup_cnt,
    output pm_state_e        state
);

    pm_state_e        state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt_q;
        unique case (state)
            PM_RUN: begin
                if (mode_wr)
                    state_nx = pm_target(mode_req);
            end
            PM_IDLE: begin
                if (irq_any || wake_any)
                    state_nx = PM_RUN;
            end
            PM_PDOWN: begin
                if (wake_any) begin
                    state_nx = PM_OSCWAIT;
                    cnt_nx   = startup_cnt;
                end
            end
            PM_OSCWAIT: begin
                if (cnt_q == '0)
                    state_nx = PM_RUN;
                else
                    cnt_nx = cnt_q - 1'b1;
            end
            default: state_nx = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PM_RUN;
            cnt_q <= '0;
        end else begin
            state <= state_nx;
            cnt_q <= cnt_nx;
        end
    end

    // R5
    pdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PM_PDOWN && !wake_any) |=> (state == PM_PDOWN));

    // R3
    idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PM_IDLE && (irq_any || wake_any)) |=> (state == PM_RUN));

    // R6
    startup_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PM_OSCWAIT && cnt_q != '0) |=>
            (state == PM_OSCWAIT && cnt_q == $past(cnt_q) - 1'b1));

    // R9
    run_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && !mode_wr) |=> (state == PM_RUN));

endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate
    import pm_pkg::*;
#(
    parameter int NPER = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  pm_state_e       state,
    input  logic [NPER-1:0] per_mask,
    output logic            cpu_clk_en,
    output logic            osc_en,
    output logic [NPER-1:0] periph_clk_en
);

    pm_gate_t g;

    assign g = pm_gates(state);

    genvar gi;
    generate
        for (gi = 0; gi < NPER; gi++) begin : g_per
            assign periph_clk_en[gi] = g.periph && per_mask[gi];
        end
    endgenerate

    assign cpu_clk_en = g.cpu;
    assign osc_en     = g.osc;

    // R4
    osc_off_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (!cpu_clk_en && periph_clk_en == '0));

endmodule

// File: rtl/lowpwr_ctrl.sv
module lowpwr_ctrl
    import pm_pkg::*;
#(
    parameter int NPER        = 8,
    parameter int NIRQ        = 8,
    parameter int NWAKE       = 4,
    parameter int CNT_W       = 8,
    parameter int STARTUP_RST = 12,
    parameter int WDATA_W     = pm_max(pm_max(NPER, CNT_W), 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [WDATA_W-1:0] reg_wdata,
    input  logic [NIRQ-1:0]    irq_pending,
    input  logic [NWAKE-1:0]   wake_async,
    output logic               cpu_clk_en,
    output logic [NPER-1:0]    periph_clk_en,
    output logic               osc_en
);

    pm_addr_e         addr;
    pm_req_t          req;
    pm_state_e        state;
    logic             mode_wr;
    logic             wake_any;
    logic [NWAKE-1:0] wake_sync;
    logic [NPER-1:0]  per_mask;
    logic [CNT_W-1:0] startup_cnt;

    assign addr    = pm_addr_e'(reg_addr);
    assign req     = pm_req_t'(reg_wdata[1:0]);
    assign mode_wr = reg_wr && (addr == PM_ADDR_MODE);

    pm_wake_sync #(.NWAKE(NWAKE), .STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .wake_async(wake_async),
        .wake_sync (wake_sync),
        .wake_any  (wake_any)
    );

    pm_cfg_regs #(
        .NPER(NPER), .CNT_W(CNT_W), .WDATA_W(WDATA_W), .STARTUP_RST(STARTUP_RST)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (addr),
        .reg_wdata  (reg_wdata),
        .per_mask   (per_mask),
        .startup_cnt(startup_cnt)
    );

    pm_mode_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_req   (req),
        .irq_any    (|irq_pending),
        .wake_any   (wake_any),
        .startup_cnt(startup_cnt),
        .state      (state)
    );

    pm_clk_gate #(.NPER(NPER)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .per_mask     (per_mask),
        .cpu_clk_en   (cpu_clk_en),
        .osc_en       (osc_en),
        .periph_clk_en(periph_clk_en)
    );

endmodule

// File: tb/lowpwr_ctrl_tb.sv
module lowpwr_ctrl_tb_top;

    localparam int NPER  = 8;
    localparam int NIRQ  = 8;
    localparam int NWAKE = 4;
    localparam int CNT_W = 8;
    localparam int SRST  = 12;
    localparam int WD    = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [WD-1:0]    reg_wdata = '0;
    logic [NIRQ-1:0]  irq_pending = '0;
    logic [NWAKE-1:0] wake_async = '0;
    logic             cpu_clk_en;
    logic [NPER-1:0]  periph_clk_en;
    logic             osc_en;

    always #10 clk = ~clk;

    lowpwr_ctrl #(
        .NPER(NPER), .NIRQ(NIRQ), .NWAKE(NWAKE), .CNT_W(CNT_W), .STARTUP_RST(SRST)
    ) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_pending(irq_pending), .wake_async(wake_async),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference: 0 run, 1 idle, 2 power-down, 3 start-up wait
    int m_state = 0;
    int m_cnt = 0;
    int m_mask = (1 << NPER) - 1;
    int m_start = SRST;
    int sync_q[$] = '{0, 0};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int wk;
        wk = sync_q[0];
        if (rst) begin
            m_state = 0; m_cnt = 0; m_mask = (1 << NPER) - 1; m_start = SRST;
            sync_q = '{0, 0};
        end else begin
            case (m_state)
                0: if (reg_wr && reg_addr == 2'd0) begin
                       if (reg_wdata[1]) m_state = 2;
                       else if (reg_wdata[0]) m_state = 1;
                   end
                1: if (irq_pending != 0 || wk != 0) m_state = 0;
                2: if (wk != 0) begin m_state = 3; m_cnt = m_start; end
                default: if (m_cnt == 0) m_state = 0; else m_cnt--;
            endcase
            if (reg_wr && reg_addr == 2'd1) m_mask = int'(reg_wdata[NPER-1:0]);
            if (reg_wr && reg_addr == 2'd2) m_start = int'(reg_wdata[CNT_W-1:0]);
            void'(sync_q.pop_front());
            sync_q.push_back((wake_async != 0) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        #5;
        if (cmp_on && !done) begin
            check({cur_req, " cpu_clk_en"}, int'(cpu_clk_en), (m_state == 0) ? 1 : 0);
            check({cur_req, " osc_en"}, int'(osc_en), (m_state != 2) ? 1 : 0);
            check({cur_req, " periph_clk_en"}, int'(periph_clk_en),
                  (m_state <= 1) ? m_mask : 0);
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [WD-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wake_pulse(input logic [NWAKE-1:0] w);
        @(negedge clk); wake_async = w;
        @(negedge clk); wake_async = '0;
    endtask

    task automatic measure_startup(input string req, input int exp_len);
        int n = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #5;
            if (cpu_clk_en) break;
            if (osc_en) n++;
        end
        check(req, n, exp_len);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_cycles(3);
        cmp_on = 1'b1;
        rst = 1'b0;
        // R1 reset values
        #1;
        check("R1 cpu", int'(cpu_clk_en), 1);
        check("R1 osc", int'(osc_en), 1);
        check("R1 periph", int'(periph_clk_en), 8'hFF);

        // R8 mask load
        cur_req = "R8";
        write_reg(2'd1, 8'hA5);
        #1 check("R8 mask", int'(periph_clk_en), 8'hA5);

        // R2 idle entry
        cur_req = "R2";
        write_reg(2'd0, 8'h01);
        #1 check("R2 cpu off", int'(cpu_clk_en), 0);
        check("R2 osc on", int'(osc_en), 1);
        check("R8 mask in idle", int'(periph_clk_en), 8'hA5);
        // R10 mode writes during sleep ignored
        cur_req = "R10";
        write_reg(2'd0, 8'h02);
        idle_cycles(3);
        check("R10 osc stays on", int'(osc_en), 1);

        // R3 wake from idle by interrupt
        cur_req = "R3";
        @(negedge clk); irq_pending = 8'h20;
        @(negedge clk); irq_pending = '0;
        check("R3 irq wake", int'(cpu_clk_en), 1);
        // R9 request cleared
        cur_req = "R9";
        idle_cycles(5);
        check("R9 stays run", int'(cpu_clk_en), 1);

        // R3 wake from idle by wake line
        cur_req = "R3";
        write_reg(2'd0, 8'h01);
        wake_pulse(4'b0100);
        idle_cycles(3);
        check("R3 wake line", int'(cpu_clk_en), 1);

        // R4 both bits give power-down; R7 count 5
        cur_req = "R7";
        write_reg(2'd2, 8'd5);
        cur_req = "R4";
        write_reg(2'd0, 8'h03);
        #1 check("R4 osc off", int'(osc_en), 0);
        check("R4 periph off", int'(periph_clk_en), 0);
        // R5 interrupt ignored
        cur_req = "R5";
        @(negedge clk); irq_pending = 8'hFF;
        @(negedge clk); irq_pending = '0;
        idle_cycles(4);
        check("R5 still down", int'(osc_en), 0);
        // R6 wake with start-up delay
        cur_req = "R6";
        wake_pulse(4'b0010);
        measure_startup("R6 startup len 5", 6);
        idle_cycles(2);

        // R7 zero count
        cur_req = "R7";
        write_reg(2'd2, 8'd0);
        write_reg(2'd0, 8'h02);
        wake_pulse(4'b1000);
        measure_startup("R7 startup len 0", 1);

        // R10 address 3 ignored
        cur_req = "R10";
        write_reg(2'd3, 8'h00);
        #1 check("R10 addr3 mask", int'(periph_clk_en), 8'hA5);

        // R11 reset from power-down
        cur_req = "R11";
        write_reg(2'd0, 8'h02);
        idle_cycles(2);
        rst = 1'b1;
        idle_cycles(2);
        rst = 1'b0;
        #1;
        check("R11 cpu", int'(cpu_clk_en), 1);
        check("R11 osc", int'(osc_en), 1);
        check("R11 periph", int'(periph_clk_en), 8'hFF);
        write_reg(2'd0, 8'h02);
        wake_pulse(4'b0001);
        measure_startup("R11 startup default", SRST + 1);
        idle_cycles(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule